// File: doc/BRIEF.md
# Transmit Buffer Refill Scheduler

This block sits between a per-channel transmit packet buffer and the DMA engine that fetches host data into it. It keeps a byte fill level for each channel's share of the buffer. The level falls by one for every byte handed to a transmit engine, and it rises by the size of each completed refill. When a channel is low, it asks the DMA for more data. A channel can win a refill only when it is enabled, its level is strictly below a programmable low water mark, and the DMA flags that the host has data queued for it.

When several channels qualify together, a run-time mode bit picks the winner. In fixed-priority mode the lowest-numbered channel wins. In round-robin mode the search starts just after the channel granted last. The block issues one refill request at a time, holding the channel and a byte count equal to the free space in that channel's share. The DMA answers with a single-cycle done pulse. Descriptor handling and bus transfers belong to the DMA and are not part of this block.

Top module: `tx_refill_sched`

## Requirements
- R1: While `rst` is high at a clock edge, every fill level becomes 0 and `refill_req` becomes 0.
- R2: A channel is eligible only when its `ch_enable` bit is 1, its `data_pending` bit is 1, and its level is strictly less than `low_mark`. No request is raised when no channel is eligible.
- R3: With `rr_mode` = 0 (fixed priority), the granted channel is the eligible channel with the lowest index. Channel 0 ranks highest.
- R4: With `rr_mode` = 1 (round robin), the granted channel is the first eligible channel after the last granted one, searching upward and wrapping. Every grant updates the last-granted channel in either mode. After reset the search starts at channel 0.
- R5: `refill_bytes` equals `SHARE_BYTES` minus the granted channel's level at the grant edge.
- R6: Only one request is outstanding at a time. `refill_req`, `refill_ch` and `refill_bytes` hold steady until a `refill_done` edge. After that edge `refill_req` is 0 for at least one cycle.
- R7: A `refill_done` while a request is outstanding adds `refill_bytes` to that channel's level at the same edge. A `refill_done` with no request outstanding has no effect.
- R8: A `drain_valid` edge lowers the level of channel `drain_ch` by one. It is ignored when that level is already 0.
- R9: A channel whose `ch_enable` bit is 0 at an edge has level 0 after that edge and is never granted.
- R10: `refill_req` rises at the first clock edge at which no request is outstanding and at least one channel is eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_enable | input | NUM_CH | Per-channel enable |
| data_pending | input | NUM_CH | Per-channel host-data-queued flags from the DMA |
| low_mark | input | LVL_W | Low water mark in bytes |
| rr_mode | input | 1 | 1 = round robin, 0 = fixed priority |
| drain_valid | input | 1 | One byte delivered to a transmit engine |
| drain_ch | input | CH_W | Channel of the delivered byte |
| refill_req | output | 1 | Refill request outstanding |
| refill_ch | output | CH_W | Channel to refill |
| refill_bytes | output | LVL_W | Bytes to fetch |
| refill_done | input | 1 | Single-cycle completion of the outstanding refill |
| fill_levels | output | NUM_CH*LVL_W | Current levels, channel c at bits [c*LVL_W +: LVL_W] |

## Verification
The request and all three of its fields change at the clock edge where eligibility is seen. A level change from a drain or a completion is visible right after the edge that carried it, so every result is due one edge after its stimulus. The bench drives inputs at the falling edge and advances its own model at the rising edge. It then compares the request fields and all levels at the next falling edge. Directed cases with literal expected values cover the idle-done, zero-drain, disabled-channel and round-robin rotation corners, and a seeded random phase compares against the model every cycle.

// File: rtl/tbrs_pkg.sv
package tbrs_pkg;
  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_ROUND = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/tbrs_arbiter.sv
module tbrs_arbiter
  import tbrs_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] elig,
  input  arb_mode_e         mode,
  input  logic [CH_W-1:0]   last,
  output logic              found,
  output logic [CH_W-1:0]   pick
);
  always_comb begin
    int start;
    found = 1'b0;
    pick  = '0;
    start = (mode == ARB_ROUND) ? ((int'(last) + 1) % NUM_CH) : 0;
    for (int k = 0; k < NUM_CH; k++) begin
      int idx;
      idx = (start + k) % NUM_CH;
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = CH_W'(idx);
      end
    end
  end
endmodule

// File: rtl/tbrs_level_bank.sv
module tbrs_level_bank #(
  parameter int NUM_CH      = 8,
  parameter int SHARE_BYTES = 64,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int LVL_W = $clog2(SHARE_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic                    drain_valid,
  input  logic [CH_W-1:0]         drain_ch,
  input  logic                    add_valid,
  input  logic [CH_W-1:0]         add_ch,
  input  logic [LVL_W-1:0]        add_bytes,
  output logic [NUM_CH*LVL_W-1:0] levels
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] inc_b;
    logic             dec_b;

    assign inc_b = (add_valid && add_ch == CH_W'(g)) ? add_bytes : '0;
    assign dec_b = drain_valid && drain_ch == CH_W'(g) && lvl_q != '0;

    always_ff @(posedge clk) begin
      if (rst || !ch_en[g]) lvl_q <= '0;
      else                  lvl_q <= lvl_q + inc_b - LVL_W'(dec_b);
    end

    assign levels[g*LVL_W +: LVL_W] = lvl_q;
  end
endmodule

// File: rtl/tx_refill_sched.sv
module tx_refill_sched
  import tbrs_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SHARE_BYTES = 64,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int LVL_W = $clog2(SHARE_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       ch_enable,
  input  logic [NUM_CH-1:0]       data_pending,
  input  logic [LVL_W-1:0]        low_mark,
  input  logic                    rr_mode,
  input  logic                    drain_valid,
  input  logic [CH_W-1:0]         drain_ch,
  output logic                    refill_req,
  output logic [CH_W-1:0]         refill_ch,
  output logic [LVL_W-1:0]        refill_bytes,
  input  logic                    refill_done,
  output logic [NUM_CH*LVL_W-1:0] fill_levels
);
  logic [LVL_W-1:0]  lvl [NUM_CH];
  logic [NUM_CH-1:0] elig;
  logic              found;
  logic [CH_W-1:0]   pick;
  logic              req_q;
  logic [CH_W-1:0]   ch_q;
  logic [CH_W-1:0]   last_q;
  logic [LVL_W-1:0]  bytes_q;

  tbrs_level_bank #(.NUM_CH(NUM_CH), .SHARE_BYTES(SHARE_BYTES)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .ch_en       (ch_enable),
    .drain_valid (drain_valid),
    .drain_ch    (drain_ch),
    .add_valid   (req_q && refill_done),
    .add_ch      (ch_q),
    .add_bytes   (bytes_q),
    .levels      (fill_levels)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_elig
    assign lvl[g]  = fill_levels[g*LVL_W +: LVL_W];
    assign elig[g] = ch_enable[g] && data_pending[g] && (lvl[g] < low_mark);
  end

  tbrs_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .elig  (elig),
    .mode  (arb_mode_e'(rr_mode)),
    .last  (last_q),
    .found (found),
    .pick  (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      ch_q    <= '0;
      bytes_q <= '0;
      last_q  <= CH_W'(NUM_CH - 1);
    end else if (req_q) begin
      if (refill_done) req_q <= 1'b0;
    end else if (found) begin
      req_q   <= 1'b1;
      ch_q    <= pick;
      bytes_q <= LVL_W'(SHARE_BYTES) - lvl[pick];
      last_q  <= pick;
    end
  end

  assign refill_req   = req_q;
  assign refill_ch    = ch_q;
  assign refill_bytes = bytes_q;
endmodule

// File: rtl/tx_refill_sched_chk.sv
module tx_refill_sched_chk #(
  parameter int NUM_CH      = 8,
  parameter int SHARE_BYTES = 64,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int LVL_W = $clog2(SHARE_BYTES + 1)
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_CH-1:0]       ch_enable,
  input logic [NUM_CH-1:0]       data_pending,
  input logic [LVL_W-1:0]        low_mark,
  input logic                    refill_req,
  input logic [CH_W-1:0]         refill_ch,
  input logic [LVL_W-1:0]        refill_bytes,
  input logic                    refill_done,
  input logic [NUM_CH*LVL_W-1:0] fill_levels
);
  a_r6_hold_fields: assert property (@(posedge clk) disable iff (rst)
    refill_req && !refill_done |=> refill_req && $stable(refill_ch) && $stable(refill_bytes));

  a_r6_gap_after_done: assert property (@(posedge clk) disable iff (rst)
    refill_req && refill_done |=> !refill_req);

  a_r5_size_bound: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> refill_bytes <= LVL_W'(SHARE_BYTES));

  a_r2_grant_eligible: assert property (@(posedge clk) disable iff (rst)
    $rose(refill_req) |->
      ((($past(ch_enable) & $past(data_pending)) >> refill_ch) & NUM_CH'(1)) != '0
      && LVL_W'($past(fill_levels) >> (32'(refill_ch) * LVL_W)) < $past(low_mark));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lvl
    a_r9_disabled_zero: assert property (@(posedge clk) disable iff (rst)
      !ch_enable[g] |=> fill_levels[g*LVL_W +: LVL_W] == '0);

    a_r7_level_bound: assert property (@(posedge clk) disable iff (rst)
      fill_levels[g*LVL_W +: LVL_W] <= LVL_W'(SHARE_BYTES));
  end
endmodule

bind tx_refill_sched tx_refill_sched_chk #(.NUM_CH(NUM_CH), .SHARE_BYTES(SHARE_BYTES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ch_enable    (ch_enable),
  .data_pending (data_pending),
  .low_mark     (low_mark),
  .refill_req   (refill_req),
  .refill_ch    (refill_ch),
  .refill_bytes (refill_bytes),
  .refill_done  (refill_done),
  .fill_levels  (fill_levels)
);

// File: tb/tx_refill_sched_bench.sv
`timescale 1ns/1ps
module tx_refill_sched_bench;
  localparam int NUM_CH = 8;
  localparam int SHARE  = 64;
  localparam int CH_W   = 3;
  localparam int LVL_W  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_CH-1:0] ch_enable = '0, data_pending = '0;
  logic [LVL_W-1:0] low_mark = '0;
  logic rr_mode = 1'b0, drain_valid = 1'b0, refill_done = 1'b0;
  logic [CH_W-1:0] drain_ch = '0;
  logic refill_req;
  logic [CH_W-1:0] refill_ch;
  logic [LVL_W-1:0] refill_bytes;
  logic [NUM_CH*LVL_W-1:0] fill_levels;

  always #4 clk = ~clk;

  tx_refill_sched #(.NUM_CH(NUM_CH), .SHARE_BYTES(SHARE)) u_tx_refill_sched (
    .clk(clk), .rst(rst), .ch_enable(ch_enable), .data_pending(data_pending),
    .low_mark(low_mark), .rr_mode(rr_mode), .drain_valid(drain_valid),
    .drain_ch(drain_ch), .refill_req(refill_req), .refill_ch(refill_ch),
    .refill_bytes(refill_bytes), .refill_done(refill_done), .fill_levels(fill_levels)
  );

  int n_chk = 0, n_fail = 0;
  int m_lvl [NUM_CH];
  bit m_req;
  int m_ch, m_bytes, m_last;

  function automatic int dut_lvl(int c);
    return int'(fill_levels[c*LVL_W +: LVL_W]);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int g = -1;
    int nl [NUM_CH];
    if (rst) begin
      foreach (m_lvl[c]) m_lvl[c] = 0;
      m_req = 0; m_ch = 0; m_bytes = 0; m_last = NUM_CH - 1;
      return;
    end
    if (!m_req) begin
      int s = rr_mode ? (m_last + 1) % NUM_CH : 0;
      for (int k = 0; k < NUM_CH; k++) begin
        int idx = (s + k) % NUM_CH;
        if (g < 0 && ch_enable[idx] && data_pending[idx] && m_lvl[idx] < int'(low_mark)) g = idx;
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (!ch_enable[c]) nl[c] = 0;
      else begin
        nl[c] = m_lvl[c];
        if (m_req && refill_done && m_ch == c) nl[c] += m_bytes;
        if (drain_valid && int'(drain_ch) == c && m_lvl[c] > 0) nl[c] -= 1;
      end
    end
    if (m_req) begin
      if (refill_done) m_req = 0;
    end else if (g >= 0) begin
      m_req = 1; m_ch = g; m_bytes = SHARE - m_lvl[g]; m_last = g;
    end
    foreach (m_lvl[c]) m_lvl[c] = nl[c];
  endtask

  task automatic compare_all();
    check(refill_req == m_req, "R10", "refill_req", int'(refill_req), int'(m_req));
    if (m_req && refill_req) begin
      check(int'(refill_ch) == m_ch, rr_mode ? "R4" : "R3", "refill_ch", int'(refill_ch), m_ch);
      check(int'(refill_bytes) == m_bytes, "R5", "refill_bytes", int'(refill_bytes), m_bytes);
    end
    for (int c = 0; c < NUM_CH; c++)
      check(dut_lvl(c) == m_lvl[c], "R8", $sformatf("level ch%0d", c), dut_lvl(c), m_lvl[c]);
  endtask

  // inputs are set after a falling edge; model advances at the rising edge; compare at next falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int first;
    int s;
    s = $urandom(32'd1234);
    @(negedge clk);
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    // R1: reset state
    check(refill_req == 1'b0, "R1", "req after reset", int'(refill_req), 0);
    for (int c = 0; c < NUM_CH; c++) check(dut_lvl(c) == 0, "R1", "level after reset", dut_lvl(c), 0);

    // R2: enabled, low, but nothing pending -> no request
    ch_enable = '1; low_mark = 7'd10; rr_mode = 1'b0;
    step(); step(); step();
    check(refill_req == 1'b0, "R2", "req with no pending", int'(refill_req), 0);

    // R3/R10/R5: fixed priority picks lowest of channels 2,5,7, one edge later
    data_pending = 8'b1010_0100;
    step();
    check(refill_req == 1'b1, "R10", "req rise", int'(refill_req), 1);
    check(refill_ch == 3'd2, "R3", "fixed pick", int'(refill_ch), 2);
    check(refill_bytes == 7'd64, "R5", "bytes", int'(refill_bytes), 64);
    step(); step();
    check(refill_req && refill_ch == 3'd2, "R6", "held while waiting", int'(refill_ch), 2);
    refill_done = 1'b1; step(); refill_done = 1'b0;
    check(refill_req == 1'b0, "R6", "gap after done", int'(refill_req), 0);
    check(dut_lvl(2) == 64, "R7", "level after done", dut_lvl(2), 64);
    step();
    check(refill_ch == 3'd5, "R3", "next fixed pick", int'(refill_ch), 5);
    refill_done = 1'b1; step(); refill_done = 1'b0;
    step();
    check(refill_ch == 3'd7, "R3", "third fixed pick", int'(refill_ch), 7);
    refill_done = 1'b1; step(); refill_done = 1'b0;
    step();
    check(refill_req == 1'b0, "R2", "no req when all above mark", int'(refill_req), 0);

    // R7: done with nothing outstanding is ignored
    data_pending = '0;
    refill_done = 1'b1; step(); refill_done = 1'b0;
    check(dut_lvl(2) == 64 && dut_lvl(0) == 0, "R7", "idle done level ch2", dut_lvl(2), 64);

    // R8: drain at zero ignored, drain at nonzero decrements
    drain_valid = 1'b1; drain_ch = 3'd0; step();
    check(dut_lvl(0) == 0, "R8", "drain at zero", dut_lvl(0), 0);
    drain_ch = 3'd5; step(); drain_valid = 1'b0;
    check(dut_lvl(5) == 63, "R8", "drain decrement", dut_lvl(5), 63);

    // R9: disabled channel zeroed and never granted
    ch_enable[5] = 1'b0; data_pending = 8'b0010_0000; step();
    check(dut_lvl(5) == 0, "R9", "disabled level", dut_lvl(5), 0);
    step(); step();
    check(refill_req == 1'b0, "R9", "disabled not granted", int'(refill_req), 0);

    // R4: round robin alternates between channels 1 and 6
    ch_enable = '0; step(); ch_enable = '1;
    rr_mode = 1'b1; data_pending = 8'b0100_0010;
    step();
    first = int'(refill_ch);
    refill_done = 1'b1; step(); refill_done = 1'b0;
    drain_valid = 1'b1; drain_ch = CH_W'(first);
    for (int i = 0; i < 64; i++) step();
    drain_valid = 1'b0;
    step();
    check(refill_req && int'(refill_ch) != first, "R4", "rotated pick", int'(refill_ch), (first == 1) ? 6 : 1);
    refill_done = 1'b1; step(); refill_done = 1'b0;

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 97 == 0) rr_mode = $urandom_range(0, 1);
      if (i % 53 == 0) ch_enable = 8'($urandom) | 8'($urandom);
      if (i % 31 == 0) low_mark = 7'($urandom_range(0, 70));
      data_pending = 8'($urandom);
      drain_valid = ($urandom_range(0, 3) != 0);
      drain_ch = 3'($urandom);
      refill_done = m_req ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 15) == 0);
      step();
    end
    refill_done = 1'b0;
    summary();
  end
endmodule